// File: doc/BRIEF.md
# Digit to Morse LED sequencer

The block takes one decimal digit together with a single-cycle start strobe. The digit typically comes from a classifier that picks the highest of ten scores. The block then plays that digit's Morse code on an LED bar, one symbol after another. Dots and dashes have the same length in time. They differ in how much of the bar lights: a dot lights only the upper half of the bar, and a dash lights the whole bar.

Each symbol has a lit phase and then a dark phase. Both phase lengths are parameters counted in clock cycles. While playback runs, a busy flag is high. A one-cycle done pulse marks the end of playback. The symbol table for the ten digits is computed inside the block. A digit outside the legal range is dropped. A strobe that arrives during playback does not disturb the sequence that is running.

Top module: `morse_digit_player`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, the LED bus is 0x00 and busy and done are both low.
- R2: A dot drives the LED bus to 0xF0 (upper four LEDs on) for exactly LIT_TICKS cycles.
- R3: A dash drives the LED bus to 0xFF (all eight LEDs on) for exactly LIT_TICKS cycles.
- R4: Every lit phase is followed by exactly DARK_TICKS cycles with the bus at 0x00.
- R5: Every digit plays five symbols.
  - Digit n from 1 to 5 is n dots and then dashes.
  - Digit n from 6 to 9 is n-5 dashes and then dots.
  - Digit 0 is five dashes.
  - The first symbol is lit in the cycle right after the start strobe is sampled.
- R6: Busy is high from the cycle after an accepted start until the done cycle, inclusive. Done is high for one cycle after the last dark phase, with the bus at 0x00. In the next cycle busy and done are both low.
- R7: A start strobe sampled while busy is high has no effect. The running sequence continues unchanged, and the block does not restart after done.
- R8: A start strobe with a digit above 9 is rejected. Busy stays low, done stays low and the bus stays at 0x00.
- R9: The LED bus only ever carries 0x00, 0xF0 or 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start strobe, sampled on the rising edge |
| digit_i | input | 4 | Digit to play, legal values 0 to 9 |
| led_o | output | LED_W | LED bar, one bit per LED |
| busy_o | output | 1 | High while playback runs |
| done_o | output | 1 | One-cycle pulse when playback ends |

## Verification
Some properties hold on every cycle, and the assertions check them:
- the bus only ever carries one of the three legal values;
- a lit phase never overruns its limit;
- the bus goes dark after every lit phase;
- done is always followed by idle;
- a rejected digit never raises busy;
- a start sampled while busy never changes the latched code.

Other properties only the bench scenarios can show:
- that each digit plays the right dot and dash order;
- that the lit and dark windows have exactly the stated lengths;
- that a strobe injected mid-sequence, or during the done cycle, leaves the visible waveform unchanged.

// File: rtl/morse_seq_pkg.sv
`timescale 1ns/1ps
package morse_seq_pkg;
  localparam int unsigned SYM_PER_DIGIT = 5;
  localparam int unsigned DIGIT_W       = 4;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_LIT  = 2'd1,
    PH_DARK = 2'd2,
    PH_END  = 2'd3
  } play_state_t;

  // A digit is playable when it lies in 0..9.
  function automatic logic digit_legal(input logic [DIGIT_W-1:0] d);
    return d <= DIGIT_W'(9);
  endfunction

  // True when symbol position pos (0 = first played) of digit d is a dash.
  function automatic logic sym_is_dash(input logic [DIGIT_W-1:0] d,
                                       input int unsigned pos);
    int unsigned dv;
    dv = int'(d);
    if (dv == 0)      return 1'b1;
    else if (dv <= 5) return pos >= dv;
    else              return pos < (dv - 5);
  endfunction
endpackage

// File: rtl/morse_table.sv
`timescale 1ns/1ps
module morse_table
  import morse_seq_pkg::*;
#(
  parameter int unsigned SYMS = SYM_PER_DIGIT
) (
  input  logic [DIGIT_W-1:0] digit_i,
  output logic [SYMS-1:0]    code_o,
  output logic               ok_o
);
  // One bit per symbol: 1 = dash, 0 = dot; bit 0 is played first.
  for (genvar g = 0; g < SYMS; g++) begin : g_sym
    assign code_o[g] = sym_is_dash(digit_i, g);
  end

  assign ok_o = digit_legal(digit_i);
endmodule

// File: rtl/morse_phase_timer.sv
`timescale 1ns/1ps
module morse_phase_timer #(
  parameter int unsigned LIT_TICKS  = 50_000_000,
  parameter int unsigned DARK_TICKS = 50_000_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart_i,
  input  logic run_i,
  input  logic dark_i,
  output logic end_o
);
  localparam int unsigned MAXT = (LIT_TICKS > DARK_TICKS) ? LIT_TICKS : DARK_TICKS;
  localparam int unsigned CW   = $clog2(MAXT + 1);
  localparam logic [CW-1:0] LIT_LAST  = CW'(LIT_TICKS - 1);
  localparam logic [CW-1:0] DARK_LAST = CW'(DARK_TICKS - 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] lim;

  assign lim   = dark_i ? DARK_LAST : LIT_LAST;
  assign end_o = run_i && (cnt_q == lim);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         cnt_q <= '0;
    else if (restart_i) cnt_q <= '0;
    else if (run_i)     cnt_q <= cnt_q + 1'b1;
  end

  // R2 R3 R4: a running phase never counts past its own limit
  phase_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run_i |-> (cnt_q <= lim));
endmodule

// File: rtl/morse_led_drv.sv
`timescale 1ns/1ps
module morse_led_drv #(
  parameter int unsigned LED_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic             dash_i,
  input  logic             blank_i,
  output logic [LED_W-1:0] led_o
);
  localparam logic [LED_W-1:0] BAR_FULL = '1;
  localparam logic [LED_W-1:0] BAR_HALF = BAR_FULL << (LED_W / 2);

  logic [LED_W-1:0] led_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       led_q <= '0;
    else if (load_i)  led_q <= dash_i ? BAR_FULL : BAR_HALF;
    else if (blank_i) led_q <= '0;
  end

  assign led_o = led_q;

  // R9
  led_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (led_q == '0) || (led_q == BAR_HALF) || (led_q == BAR_FULL));

  // R4
  dark_after_lit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    blank_i |=> (led_q == '0));
endmodule

// File: rtl/morse_play_fsm.sv
`timescale 1ns/1ps
module morse_play_fsm
  import morse_seq_pkg::*;
#(
  parameter int unsigned SYMS = SYM_PER_DIGIT
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start_i,
  input  logic            ok_i,
  input  logic [SYMS-1:0] code_i,
  input  logic            phase_end_i,
  output logic            busy_o,
  output logic            done_o,
  output logic            load_o,
  output logic            dash_o,
  output logic            blank_o,
  output logic            run_o,
  output logic            dark_o,
  output logic            restart_o
);
  localparam int unsigned IW = $clog2(SYMS);

  play_state_t     state_q;
  logic [IW-1:0]   idx_q;
  logic [SYMS-1:0] code_q;

  // named internal events
  logic            accept;
  logic            last_sym;
  logic [IW-1:0]   nxt_idx;
  logic [SYMS-1:0] code_sh;
  logic            step_sym;

  assign accept   = (state_q == PH_IDLE) && start_i && ok_i;
  assign last_sym = (idx_q == IW'(SYMS - 1));
  assign nxt_idx  = idx_q + 1'b1;
  assign code_sh  = code_q >> nxt_idx;
  assign step_sym = (state_q == PH_DARK) && phase_end_i && !last_sym;

  assign load_o    = accept || step_sym;
  assign dash_o    = accept ? code_i[0] : code_sh[0];
  assign blank_o   = (state_q == PH_LIT) && phase_end_i;
  assign run_o     = (state_q == PH_LIT) || (state_q == PH_DARK);
  assign dark_o    = (state_q == PH_DARK);
  assign restart_o = accept || phase_end_i;
  assign busy_o    = (state_q != PH_IDLE);
  assign done_o    = (state_q == PH_END);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= PH_IDLE;
      idx_q   <= '0;
      code_q  <= '0;
    end else begin
      unique case (state_q)
        PH_IDLE: if (accept) begin
          state_q <= PH_LIT;
          idx_q   <= '0;
          code_q  <= code_i;
        end
        PH_LIT: if (phase_end_i) state_q <= PH_DARK;
        PH_DARK: if (phase_end_i) begin
          if (last_sym) state_q <= PH_END;
          else begin
            state_q <= PH_LIT;
            idx_q   <= nxt_idx;
          end
        end
        PH_END:  state_q <= PH_IDLE;
        default: state_q <= PH_IDLE;
      endcase
    end
  end

  // R6
  done_then_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> (!busy_o && !done_o));

  // R8
  reject_digit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && start_i && !ok_i) |=> !busy_o);

  // R7
  busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && start_i) |=> $stable(code_q));

  // R5
  symbol_idx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> (idx_q <= IW'(SYMS - 1)));
endmodule

// File: rtl/morse_digit_player.sv
`timescale 1ns/1ps
module morse_digit_player
  import morse_seq_pkg::*;
#(
  parameter int unsigned LED_W      = 8,
  parameter int unsigned LIT_TICKS  = 50_000_000,
  parameter int unsigned DARK_TICKS = 50_000_000
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start_i,
  input  logic [DIGIT_W-1:0] digit_i,
  output logic [LED_W-1:0]   led_o,
  output logic               busy_o,
  output logic               done_o
);
  localparam int unsigned SYMS = SYM_PER_DIGIT;

  logic [SYMS-1:0] code;
  logic            ok;
  logic            phase_end;
  logic            load;
  logic            dash;
  logic            blank;
  logic            run;
  logic            dark;
  logic            restart;

  morse_table #(.SYMS(SYMS)) u_table (
    .digit_i (digit_i),
    .code_o  (code),
    .ok_o    (ok)
  );

  morse_play_fsm #(.SYMS(SYMS)) u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .ok_i        (ok),
    .code_i      (code),
    .phase_end_i (phase_end),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .load_o      (load),
    .dash_o      (dash),
    .blank_o     (blank),
    .run_o       (run),
    .dark_o      (dark),
    .restart_o   (restart)
  );

  morse_phase_timer #(.LIT_TICKS(LIT_TICKS), .DARK_TICKS(DARK_TICKS)) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .restart_i (restart),
    .run_i     (run),
    .dark_i    (dark),
    .end_o     (phase_end)
  );

  morse_led_drv #(.LED_W(LED_W)) u_led (
    .clk     (clk),
    .rst_n   (rst_n),
    .load_i  (load),
    .dash_i  (dash),
    .blank_i (blank),
    .led_o   (led_o)
  );
endmodule

// File: tb/tb_morse_digit_player.sv
`timescale 1ns/1ps
module tb_morse_digit_player;
  localparam int LIT  = 3;
  localparam int DARK = 2;

  // {digit, symbols}: symbol bit 0 plays first, 1 = dash
  localparam logic [8:0] VEC [10] = '{
    {4'd0, 5'b11111}, {4'd1, 5'b11110}, {4'd2, 5'b11100}, {4'd3, 5'b11000},
    {4'd4, 5'b10000}, {4'd5, 5'b00000}, {4'd6, 5'b00001}, {4'd7, 5'b00011},
    {4'd8, 5'b00111}, {4'd9, 5'b01111}
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic [3:0] digit = 4'd0;
  logic [7:0] led;
  logic       busy;
  logic       done;
  int errs  = 0;
  int total = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  morse_digit_player #(.LED_W(8), .LIT_TICKS(LIT), .DARK_TICKS(DARK)) dut (
    .clk(clk), .rst_n(rst_n), .start_i(start), .digit_i(digit),
    .led_o(led), .busy_o(busy), .done_o(done)
  );

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic play(input logic [3:0] d, input logic [4:0] code, input bit inject);
    @(negedge clk);
    digit = d;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int s = 0; s < 5; s++) begin
      for (int c = 0; c < LIT; c++) begin
        // R5 R2 R3: dot 0xF0, dash 0xFF in digit order
        check(code[s] ? "R5 R3 lit dash" : "R5 R2 lit dot", led, code[s] ? 8'hFF : 8'hF0);
        check("R6 busy in lit", busy, 1);
        if (inject && s == 2 && c == 0) begin
          start = 1'b1;  // R7: ignored mid-sequence
          digit = 4'd7;
        end
        @(negedge clk);
        start = 1'b0;
      end
      for (int c = 0; c < DARK; c++) begin
        check("R4 R9 dark gap", led, 8'h00);
        @(negedge clk);
      end
    end
    check("R6 done pulse", done, 1);
    check("R6 dark at done", led, 8'h00);
    if (inject) begin
      start = 1'b1;  // R7: strobe during the done cycle
      digit = 4'd3;
    end
    @(negedge clk);
    start = 1'b0;
    check("R6 R7 idle after done", busy, 0);
    check("R6 done one cycle", done, 0);
    if (inject) begin
      @(negedge clk);
      check("R7 no restart", busy, 0);
      check("R7 bus dark", led, 8'h00);
    end
  endtask

  initial begin
    #(20 * 50000);
    if (!finished) begin
      errs++;
      total++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errs, total);
      $finish;
    end
  end

  initial begin
    #1;
    check("R1 led in reset", led, 8'h00);
    check("R1 busy in reset", busy, 0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 led after reset", led, 8'h00);
    check("R1 busy after reset", busy, 0);
    check("R1 done after reset", done, 0);

    for (int i = 0; i < 10; i++) play(VEC[i][8:5], VEC[i][4:0], 1'b0);

    // R7: extra strobes during playback of digit 8
    play(4'd8, 5'b00111, 1'b1);

    // R8: out-of-range digits rejected
    foreach (VEC[k]) begin end
    for (int b = 10; b < 16; b += 5) begin
      @(negedge clk);
      digit = 4'(b);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      for (int c = 0; c < 3; c++) begin
        check("R8 busy stays low", busy, 0);
        check("R8 bus stays dark", led, 8'h00);
        check("R8 no done", done, 0);
        @(negedge clk);
      end
    end

    // R1: reset during playback clears everything
    @(negedge clk);
    digit = 4'd0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check("R3 lit before reset", led, 8'hFF);
    rst_n = 1'b0;
    #1;
    check("R1 led mid reset", led, 8'h00);
    check("R1 busy mid reset", busy, 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 idle after reset", busy, 0);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errs, total);
    $finish;
  end
endmodule